// File: doc/BRIEF.md
# NAND Bus Cycle Decoder

This block is the device-side front end of a multiplexed NAND-style parallel bus. Eight or sixteen I/O lines and a set of active-low control strobes arrive with no timing relation to the system clock. The block passes them through a two-flop synchronizer and detects each rising edge of the write strobe. It then sorts the cycle into a command, address, data-input or illegal cycle, using the levels of chip enable, command latch, address latch and read enable at that edge.

Each recognized cycle gives a single-cycle strobe. A command cycle gives the command byte. An address cycle gives the address byte and its position counted from the last command. A data cycle gives the data word with the cache column it is meant for. The column counter takes its start value from the two leading address bytes once the fifth address byte has arrived. It then steps by one per data cycle and flags any column past the end of the page. The strobes feed a command sequencer and a cache buffer write port elsewhere in the chip.

Top module: `nand_bus_decoder`

## Requirements
- R1: A write-strobe rising edge with chip enable low, command latch high and address latch low is a command cycle. It gives a one-cycle `cmd_stb_o` with `cmd_byte_o` equal to I/O[7:0]. The read-enable level does not matter for this cycle.
- R2: A write-strobe rising edge with chip enable low, address latch high, command latch low and read enable high is an address cycle. It gives a one-cycle `addr_stb_o` with `addr_byte_o` equal to I/O[7:0] and `addr_idx_o` equal to the position of the byte.
- R3: A write-strobe rising edge with chip enable low, both latches low and read enable high is a data cycle. It gives a one-cycle `din_stb_o` with the data word on `din_data_o`.
- R4: Every command cycle sets the address position back to 0. Each address cycle moves it up by one, and it stays at 7 once it reaches 7.
- R5: The address byte at position 4 (the fifth) loads the column counter with {byte 1 bits [3:0], byte 0}. Each data cycle presents the current column on `din_col_o` and then adds one, stopping at 4095.
- R6: `col_err_o` goes high together with `din_stb_o` when the presented column is 2112 or more in 8-bit mode, or 1056 or more in 16-bit mode.
- R7: Commands and addresses use only I/O[7:0]. In 8-bit mode (`wide_i` = 0) `din_data_o[15:8]` is zero. In 16-bit mode `din_data_o` carries all sixteen lines.
- R8: A write-strobe rising edge with chip enable low and both latches high gives a one-cycle `illegal_o` and no other strobe. The address position and the column are left as they were.
- R9: A write-strobe edge with chip enable high produces no strobe. An address or data edge with read enable low also produces no strobe.
- R10: At most one of the four strobes is high in any cycle, and no strobe stays high for two cycles in a row.
- R11: After reset all strobes are low and the column counter is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wide_i | input | 1 | 1 selects the 16-bit bus, 0 the 8-bit bus |
| nce_i | input | 1 | Chip enable, active low |
| cle_i | input | 1 | Command latch enable |
| ale_i | input | 1 | Address latch enable |
| nre_i | input | 1 | Read enable, active low |
| nwe_i | input | 1 | Write strobe, cycle captured on its rising edge |
| io_i | input | 16 | Bus I/O lines |
| cmd_stb_o | output | 1 | Command cycle pulse |
| cmd_byte_o | output | 8 | Captured command byte |
| addr_stb_o | output | 1 | Address cycle pulse |
| addr_idx_o | output | 3 | Position of the address byte since the last command |
| addr_byte_o | output | 8 | Captured address byte |
| din_stb_o | output | 1 | Data cycle pulse (cache write enable) |
| din_col_o | output | 12 | Cache column for the data word |
| din_data_o | output | 16 | Data word |
| col_err_o | output | 1 | Column beyond page end, valid with din_stb_o |
| illegal_o | output | 1 | Both latches high on a write edge |

## Verification
Every result of a bus edge reaches the outputs on the third clock edge after the write strobe rises at the pins. Two clock edges go through the synchronizer and one through the output register, and control and data travel in the same synchronizer so they stay aligned. The bench raises the write strobe on a falling clock edge and counts three rising edges. It samples at the falling edge that follows, and samples again one cycle later to check that the pulse has ended. Expected values come from a bench model of the position and column counters that is updated once per bus edge. Random bus cycles run alongside directed cases for the page boundary, position saturation and the illegal combination.

// File: rtl/nbd_pkg.sv
package nbd_pkg;

  typedef enum logic [2:0] {
    CYC_NONE,
    CYC_CMD,
    CYC_ADDR,
    CYC_DATA,
    CYC_BAD
  } cyc_e;

  // Sort a bus edge by its control levels (active-low nce/nre).
  function automatic cyc_e decode_cycle(input logic nce, input logic cle,
                                        input logic ale, input logic nre);
    cyc_e k;
    k = CYC_NONE;
    if (!nce) begin
      if (cle && ale)        k = CYC_BAD;
      else if (cle)          k = CYC_CMD;
      else if (ale && nre)   k = CYC_ADDR;
      else if (!ale && nre)  k = CYC_DATA;
    end
    return k;
  endfunction

  // Increment that sticks at a ceiling.
  function automatic logic [15:0] sat_inc(input logic [15:0] v, input logic [15:0] top);
    return (v >= top) ? top : v + 16'd1;
  endfunction

  // Column past the end of the page for the current bus width.
  function automatic logic col_over(input logic [15:0] col, input logic wide,
                                    input logic [15:0] page_units);
    logic [15:0] lim;
    lim = wide ? (page_units >> 1) : page_units;
    return col >= lim;
  endfunction

endpackage

// File: rtl/nbd_sync.sv
module nbd_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      stage_q[s] <= RST_VAL;
      else if (s == 0) stage_q[s] <= d_i;
      else             stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/nbd_classify.sv
module nbd_classify
  import nbd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic nwe_s,
  input  logic nce_s,
  input  logic cle_s,
  input  logic ale_s,
  input  logic nre_s,
  output logic we_rise,
  output cyc_e cyc
);
  logic nwe_prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) nwe_prev_q <= 1'b1;
    else        nwe_prev_q <= nwe_s;
  end

  assign we_rise = nwe_s && !nwe_prev_q;
  assign cyc     = we_rise ? decode_cycle(nce_s, cle_s, ale_s, nre_s) : CYC_NONE;
endmodule

// File: rtl/nbd_track.sv
module nbd_track
  import nbd_pkg::*;
#(
  parameter int unsigned IO_W       = 16,
  parameter int unsigned COL_W      = 12,
  parameter int unsigned IDX_W      = 3,
  parameter int unsigned PAGE_UNITS = 2112,
  parameter int unsigned LOAD_POS   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  cyc_e             cyc,
  input  logic [IO_W-1:0]  io_s,
  input  logic             wide_s,
  output logic             cmd_stb,
  output logic [7:0]       cmd_byte,
  output logic             addr_stb,
  output logic [IDX_W-1:0] addr_idx,
  output logic [7:0]       addr_byte,
  output logic             din_stb,
  output logic [COL_W-1:0] din_col,
  output logic [IO_W-1:0]  din_data,
  output logic             col_err,
  output logic             illegal,
  output logic [IDX_W-1:0] addr_cnt,
  output logic [COL_W-1:0] col_cnt
);
  localparam int unsigned HI_W = COL_W - 8;
  localparam logic [15:0] IDX_TOP = 16'((1 << IDX_W) - 1);
  localparam logic [15:0] COL_TOP = 16'((1 << COL_W) - 1);

  logic [7:0]      col_lo_q;
  logic [HI_W-1:0] col_hi_q;
  logic [IO_W-1:0] data_word;

  assign data_word = wide_s ? io_s : {{(IO_W-8){1'b0}}, io_s[7:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_stb   <= 1'b0;
      cmd_byte  <= '0;
      addr_stb  <= 1'b0;
      addr_idx  <= '0;
      addr_byte <= '0;
      din_stb   <= 1'b0;
      din_col   <= '0;
      din_data  <= '0;
      col_err   <= 1'b0;
      illegal   <= 1'b0;
      addr_cnt  <= '0;
      col_cnt   <= '0;
      col_lo_q  <= '0;
      col_hi_q  <= '0;
    end else begin
      cmd_stb  <= 1'b0;
      addr_stb <= 1'b0;
      din_stb  <= 1'b0;
      col_err  <= 1'b0;
      illegal  <= 1'b0;
      unique case (cyc)
        CYC_CMD: begin
          cmd_stb  <= 1'b1;
          cmd_byte <= io_s[7:0];
          addr_cnt <= '0;
        end
        CYC_ADDR: begin
          addr_stb  <= 1'b1;
          addr_idx  <= addr_cnt;
          addr_byte <= io_s[7:0];
          addr_cnt  <= IDX_W'(sat_inc(16'(addr_cnt), IDX_TOP));
          if (addr_cnt == IDX_W'(0)) col_lo_q <= io_s[7:0];
          if (addr_cnt == IDX_W'(1)) col_hi_q <= io_s[HI_W-1:0];
          if (addr_cnt == IDX_W'(LOAD_POS)) col_cnt <= {col_hi_q, col_lo_q};
        end
        CYC_DATA: begin
          din_stb  <= 1'b1;
          din_col  <= col_cnt;
          din_data <= data_word;
          col_err  <= col_over(16'(col_cnt), wide_s, 16'(PAGE_UNITS));
          col_cnt  <= COL_W'(sat_inc(16'(col_cnt), COL_TOP));
        end
        CYC_BAD: illegal <= 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/nand_bus_decoder.sv
module nand_bus_decoder
  import nbd_pkg::*;
#(
  parameter int unsigned IO_W       = 16,
  parameter int unsigned COL_W      = 12,
  parameter int unsigned IDX_W      = 3,
  parameter int unsigned PAGE_UNITS = 2112,
  parameter int unsigned SYNC_STG   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wide_i,
  input  logic             nce_i,
  input  logic             cle_i,
  input  logic             ale_i,
  input  logic             nre_i,
  input  logic             nwe_i,
  input  logic [IO_W-1:0]  io_i,
  output logic             cmd_stb_o,
  output logic [7:0]       cmd_byte_o,
  output logic             addr_stb_o,
  output logic [IDX_W-1:0] addr_idx_o,
  output logic [7:0]       addr_byte_o,
  output logic             din_stb_o,
  output logic [COL_W-1:0] din_col_o,
  output logic [IO_W-1:0]  din_data_o,
  output logic             col_err_o,
  output logic             illegal_o
);
  localparam int unsigned SW = IO_W + 6;
  localparam logic [SW-1:0] SYNC_RST = {1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, {IO_W{1'b0}}};

  logic [SW-1:0]    pins_s;
  logic [IO_W-1:0]  io_s;
  logic             wide_s, nce_s, cle_s, ale_s, nre_s, nwe_s;
  logic             we_rise;
  cyc_e             cyc;
  logic [IDX_W-1:0] addr_cnt;
  logic [COL_W-1:0] col_cnt;

  nbd_sync #(.W(SW), .STAGES(SYNC_STG), .RST_VAL(SYNC_RST)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d_i({wide_i, nce_i, cle_i, ale_i, nre_i, nwe_i, io_i}),
    .q_o(pins_s)
  );
  assign {wide_s, nce_s, cle_s, ale_s, nre_s, nwe_s, io_s} = pins_s;

  nbd_classify u_cls (
    .clk(clk), .rst_n(rst_n), .nwe_s(nwe_s), .nce_s(nce_s), .cle_s(cle_s),
    .ale_s(ale_s), .nre_s(nre_s), .we_rise(we_rise), .cyc(cyc)
  );

  nbd_track #(.IO_W(IO_W), .COL_W(COL_W), .IDX_W(IDX_W), .PAGE_UNITS(PAGE_UNITS)) u_trk (
    .clk(clk), .rst_n(rst_n), .cyc(cyc), .io_s(io_s), .wide_s(wide_s),
    .cmd_stb(cmd_stb_o), .cmd_byte(cmd_byte_o), .addr_stb(addr_stb_o),
    .addr_idx(addr_idx_o), .addr_byte(addr_byte_o), .din_stb(din_stb_o),
    .din_col(din_col_o), .din_data(din_data_o), .col_err(col_err_o),
    .illegal(illegal_o), .addr_cnt(addr_cnt), .col_cnt(col_cnt)
  );
endmodule

// File: rtl/nbd_checker.sv
module nbd_checker #(
  parameter int unsigned COL_W = 12,
  parameter int unsigned IDX_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_stb,
  input logic             addr_stb,
  input logic [IDX_W-1:0] addr_idx,
  input logic             din_stb,
  input logic [COL_W-1:0] din_col,
  input logic             col_err,
  input logic             illegal,
  input logic [IDX_W-1:0] addr_cnt,
  input logic [COL_W-1:0] col_cnt
);
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_stb, addr_stb, din_stb, illegal})); // R10

  AST_CMD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stb |=> !cmd_stb); // R10

  AST_CMD_CLEARS_POS: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stb |-> addr_cnt == '0); // R4

  AST_POS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_stb && addr_idx != '1) |-> addr_cnt == IDX_W'(addr_idx + 1'b1)); // R4

  AST_COL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (din_stb && din_col != '1) |-> col_cnt == COL_W'(din_col + 1'b1)); // R5

  AST_ERR_WITH_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    col_err |-> din_stb); // R6

  AST_ILLEGAL_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (addr_cnt == $past(addr_cnt) && col_cnt == $past(col_cnt))); // R8
endmodule

bind nand_bus_decoder nbd_checker #(.COL_W(COL_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_stb(cmd_stb_o), .addr_stb(addr_stb_o),
  .addr_idx(addr_idx_o), .din_stb(din_stb_o), .din_col(din_col_o),
  .col_err(col_err_o), .illegal(illegal_o), .addr_cnt(addr_cnt), .col_cnt(col_cnt)
);

// File: tb/nand_bus_decoder_tb.sv
module nand_bus_decoder_tb;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wide_i = 1'b0, nce_i = 1'b1, cle_i = 1'b0, ale_i = 1'b0, nre_i = 1'b1, nwe_i = 1'b1;
  logic [15:0] io_i = '0;
  logic cmd_stb_o, addr_stb_o, din_stb_o, col_err_o, illegal_o;
  logic [7:0] cmd_byte_o, addr_byte_o;
  logic [2:0] addr_idx_o;
  logic [11:0] din_col_o;
  logic [15:0] din_data_o;

  int n_chk = 0, n_bad = 0;

  // bench model state
  int m_pos = 0, m_col = 0, m_lo = 0, m_hi = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nand_bus_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .wide_i(wide_i), .nce_i(nce_i), .cle_i(cle_i),
    .ale_i(ale_i), .nre_i(nre_i), .nwe_i(nwe_i), .io_i(io_i),
    .cmd_stb_o(cmd_stb_o), .cmd_byte_o(cmd_byte_o), .addr_stb_o(addr_stb_o),
    .addr_idx_o(addr_idx_o), .addr_byte_o(addr_byte_o), .din_stb_o(din_stb_o),
    .din_col_o(din_col_o), .din_data_o(din_data_o), .col_err_o(col_err_o),
    .illegal_o(illegal_o)
  );

  task automatic check(input string req, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s got=0x%0h exp=0x%0h at %0t", req, got, exp, $time);
    end
  endtask

  task automatic report();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // 0 none, 1 command, 2 address, 3 data, 4 illegal
  function automatic int kind_of(input logic nce, input logic cle, input logic ale, input logic nre);
    if (nce) return 0;
    if (cle && ale) return 4;
    if (cle) return 1;
    if (ale) return nre ? 2 : 0;
    return nre ? 3 : 0;
  endfunction

  function automatic int limit_of(input logic wide);
    return wide ? 1056 : 2112;
  endfunction

  task automatic bus_edge(input logic nce, input logic cle, input logic ale,
                          input logic nre, input logic [15:0] d, input logic wide);
    int k;
    @(negedge clk);
    nce_i = nce; cle_i = cle; ale_i = ale; nre_i = nre; io_i = d; wide_i = wide; nwe_i = 1'b0;
    repeat (3) @(negedge clk);
    nwe_i = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    k = kind_of(nce, cle, ale, nre);
    check(k == 0 ? "R9 cmd" : "R1 cmd strobe", cmd_stb_o, k == 1);
    check(k == 0 ? "R9 addr" : "R2 addr strobe", addr_stb_o, k == 2);
    check(k == 0 ? "R9 data" : "R3 data strobe", din_stb_o, k == 3);
    check("R8 illegal strobe", illegal_o, k == 4);
    case (k)
      1: begin
        check("R1 R7 cmd byte", cmd_byte_o, d[7:0]);
        m_pos = 0;
      end
      2: begin
        check("R2 R7 addr byte", addr_byte_o, d[7:0]);
        check("R4 addr position", addr_idx_o, m_pos);
        if (m_pos == 0) m_lo = d[7:0];
        if (m_pos == 1) m_hi = d[3:0];
        if (m_pos == 4) m_col = m_hi * 256 + m_lo;
        if (m_pos < 7) m_pos++;
      end
      3: begin
        check("R5 column", din_col_o, m_col);
        check("R7 data word", din_data_o, wide ? d : {8'h00, d[7:0]});
        check("R6 column range", col_err_o, m_col >= limit_of(wide));
        if (m_col < 4095) m_col++;
      end
      default: ;
    endcase
    @(negedge clk);
    check("R10 pulse ends", {cmd_stb_o, addr_stb_o, din_stb_o, illegal_o}, 0);
  endtask

  task automatic page_cmd(input logic [7:0] c, input int col, input logic wide);
    bus_edge(0, 1, 0, 1, {8'h00, c}, wide);
    bus_edge(0, 0, 1, 1, 16'(col & 255), wide);
    bus_edge(0, 0, 1, 1, 16'(col >> 8), wide);
    for (int i = 0; i < 3; i++) bus_edge(0, 0, 1, 1, 16'(8'h11 * (i + 1)), wide);
  endtask

  initial begin
    repeat (1000000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R11 reset strobes", {cmd_stb_o, addr_stb_o, din_stb_o, illegal_o, col_err_o}, 0);
    check("R11 reset column", din_col_o, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R5 R6: page boundary in 8-bit mode
    page_cmd(8'h80, 2110, 1'b0);
    for (int i = 0; i < 4; i++) bus_edge(0, 0, 0, 1, 16'hA5C3 + 16'(i), 1'b0);
    // R6 R7: 16-bit mode boundary
    page_cmd(8'h80, 1054, 1'b1);
    for (int i = 0; i < 3; i++) bus_edge(0, 0, 0, 1, 16'hBEEF ^ 16'(i), 1'b1);
    // R4: position saturates at 7
    bus_edge(0, 1, 0, 0, 16'hFF60, 1'b0);
    for (int i = 0; i < 10; i++) bus_edge(0, 0, 1, 1, 16'(i), 1'b0);
    // R8: illegal edge keeps position
    bus_edge(0, 1, 0, 1, 16'h0090, 1'b0);
    bus_edge(0, 0, 1, 1, 16'h0001, 1'b0);
    bus_edge(0, 1, 1, 1, 16'h00AA, 1'b0);
    bus_edge(0, 0, 1, 1, 16'h0002, 1'b0);
    // R9: chip disabled, read enable low
    bus_edge(1, 1, 0, 1, 16'h0070, 1'b0);
    bus_edge(0, 0, 1, 0, 16'h0033, 1'b0);
    bus_edge(0, 0, 0, 0, 16'h0044, 1'b0);
    bus_edge(0, 0, 1, 1, 16'h0003, 1'b0);
    // R5: saturation of column at 4095
    page_cmd(8'h85, 4094, 1'b0);
    for (int i = 0; i < 3; i++) bus_edge(0, 0, 0, 1, 16'h1234, 1'b0);

    // random mix
    for (int n = 0; n < 400; n++) begin
      int r;
      logic nce, cle, ale, nre, w;
      r = $urandom_range(0, 99);
      nce = ($urandom_range(0, 9) == 0);
      nre = ($urandom_range(0, 9) != 0);
      w = (n >= 200);
      cle = (r < 12) || (r >= 95);
      ale = (r >= 12 && r < 55) || (r >= 95);
      bus_edge(nce, cle, ale, nre, 16'($urandom), w);
    end
    report();
  end
endmodule